// File: doc/BRIEF.md
# Indirectly addressed interrupt routing register file

This block holds the programmable state of an I/O interrupt controller. Software reaches it through only two bus offsets. Offset 0x00 is an 8-bit select register. Offset 0x10 is a 32-bit data window that reads or writes whichever internal register the select value names. Three small registers sit behind the window: identification, version and arbitration. A table of 64-bit routing entries also sits behind it, one entry per input pin. Each entry is reached as two 32-bit halves.

The whole table is presented in parallel on `tbl_o` for the delivery logic next to this block. That logic sets an entry's remote-pending flag through `rirr_set_i` after it hands off a level-triggered request. Software clears the flag by writing the entry's low half. Raw pin requests are captured in a pending register on `pend_o`. When a bus write flips an entry's mask bit, a one-cycle notification names the pin and the new mask value. Interrupt delivery itself happens outside this block.

Top module: `ioint_regs`

## Requirements
- R1: Writing bus offset 0x00 loads bits 7:0 of the write data into the select register. Reading offset 0x00 returns it zero-extended. Offset 0x10 is the data window. Any other offset reads 0, and a write to it changes no state.
- R2: With select 0x01, a window read returns (NPINS-1) in bits 23:16 and the version code 0x11 in bits 7:0, with all other bits 0. A window write with select 0x01 changes nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as the 4-bit ID. A window read with select 0x00 or select 0x02 returns the ID in bits 27:24 and 0 elsewhere. A window write with select 0x02 changes nothing.
- R4: Select 0x10+2n reaches bits 31:0 of entry n, and select 0x11+2n reaches bits 63:32. A write to one half leaves the other half unchanged. Select values 0x03 to 0x0F read 0, and writes through them are ignored.
- R5: A table select whose entry index (select-0x10)/2 is NPINS or more reads 0, and a write through it is dropped.
- R6: Remote-pending is entry bit 14 and cannot be set from the bus. A low-half write clears it. Pulsing `rirr_set_i[n]` sets it on the next edge. When both happen to one entry in the same cycle, the set wins.
- R7: After reset, every entry holds only its mask bit (bit 16 = 1). The select register, the ID and the pending register are 0, `rdata_o` is 0, and no notification is active.
- R8: The cycle after a write changes an entry's mask bit, `mchg_valid_o` is 1 for exactly one cycle. In that cycle `mchg_pin_o` carries the entry index and `mchg_mask_o` carries the new mask. A write that leaves the mask unchanged gives no pulse.
- R9: `tbl_o[64n+63:64n]` always equals entry n. Its fields are vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger mode 15 (1 = level), mask 16 and destination 63:56.
- R10: `pend_o` equals `req_i` as sampled at the previous clock edge.
- R11: A read (`bus_rd_i`) loads `rdata_o` at the clock edge, and `rdata_o` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_addr_i | input | 8 | Byte offset inside the block |
| bus_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rirr_set_i | input | NPINS | Per-entry remote-pending set pulse from delivery logic |
| req_i | input | NPINS | Raw pin request levels |
| pend_o | output | NPINS | Registered pending requests |
| tbl_o | output | 64*NPINS | All entries, entry n in bits 64n+63:64n |
| mchg_valid_o | output | 1 | Mask-change notification pulse |
| mchg_pin_o | output | $clog2(NPINS) | Entry whose mask changed |
| mchg_mask_o | output | 1 | New mask value |

## Verification
Two things can land on the same entry in the same cycle. Software can write the low half while the delivery logic pulses that entry's remote-pending set. The bench drives both on one edge for a chosen entry. It then expects bit 14 to read as 1 on both `tbl_o` and a window read. It also expects the mask notification from the same write to appear normally. Random writes interleaved with random set pulses exercise the same ordering against a bench model that applies the clear before the set.

// File: rtl/ioint_pkg.sv
// Package: shared constants for the indirect interrupt register file.
// Assumes entry fields at fixed bit positions that delivery logic decodes.
package ioint_pkg;
    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_WIN  = 8'h10;
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL  = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h11;
    localparam int ENT_W   = 64;
    localparam int RIRR_B  = 14;
    localparam int MASK_B  = 16;
    localparam int ID_LO   = 24;
    localparam int ID_W    = 4;

    // Read source chosen by the decoder for a window read.
    typedef enum logic [1:0] {
        RK_ZERO = 2'd0,
        RK_ID   = 2'd1,
        RK_VER  = 2'd2,
        RK_TBL  = 2'd3
    } rd_kind_e;
endpackage

// File: rtl/ioint_bus_dec.sv
// Module: ioint_bus_dec
// Decodes bus offset and current select value into per-register write
// strobes and a window read source. Assumes NPINS <= 120 so every entry
// index fits a select byte.
module ioint_bus_dec
    import ioint_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             bus_wr_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [7:0]       sel_i,
    output logic             sel_we_o,
    output logic             id_we_o,
    output logic [NPINS-1:0] wr_lo_o,
    output logic [NPINS-1:0] wr_hi_o,
    output rd_kind_e         rd_kind_o,
    output logic [6:0]       idx_o
);
    logic win_wr;
    logic tbl_sel;
    logic idx_ok;

    // Offset decode and entry index extraction.
    always_comb begin
        win_wr   = bus_wr_i && (bus_addr_i == OFS_WIN);
        sel_we_o = bus_wr_i && (bus_addr_i == OFS_SEL);
        id_we_o  = win_wr && (sel_i == SEL_ID);
        tbl_sel  = (sel_i >= SEL_TBL);
        idx_o    = sel_i[7:1] - 7'd8;
        idx_ok   = tbl_sel && (idx_o < 7'(NPINS));
    end

    // Window read source selection.
    always_comb begin
        if (sel_i == SEL_ID || sel_i == SEL_ARB) rd_kind_o = RK_ID;
        else if (sel_i == SEL_VER)               rd_kind_o = RK_VER;
        else if (idx_ok)                         rd_kind_o = RK_TBL;
        else                                     rd_kind_o = RK_ZERO;
    end

    // One strobe pair per entry.
    for (genvar n = 0; n < NPINS; n++) begin : g_strb
        assign wr_lo_o[n] = win_wr && idx_ok && (idx_o == 7'(n)) && !sel_i[0];
        assign wr_hi_o[n] = win_wr && idx_ok && (idx_o == 7'(n)) &&  sel_i[0];
    end

    // R5: at most one half of one in-range entry is written per cycle.
    always_comb begin
        a_r5_one_strobe: assert ($onehot0({wr_lo_o, wr_hi_o}));
    end
endmodule

// File: rtl/ioint_ctl_regs.sv
// Module: ioint_ctl_regs
// Holds the select register, the 4-bit ID and the pending-request register.
// Assumes write strobes come pre-decoded from ioint_bus_dec.
module ioint_ctl_regs
    import ioint_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we_i,
    input  logic             id_we_i,
    input  logic [7:0]       sel_wdata_i,
    input  logic [ID_W-1:0]  id_wdata_i,
    input  logic [NPINS-1:0] req_i,
    output logic [7:0]       sel_o,
    output logic [ID_W-1:0]  id_o,
    output logic [NPINS-1:0] pend_o
);
    // Select and ID storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= '0;
            id_o  <= '0;
        end else begin
            if (sel_we_i) sel_o <= sel_wdata_i;
            if (id_we_i)  id_o  <= id_wdata_i;
        end
    end

    // Pending-request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= req_i;
    end

    // R1: select only moves on its own write.
    a_r1_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we_i |=> $stable(sel_o));
    // R3: ID only moves on its own write.
    a_r3_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !id_we_i |=> $stable(id_o));
endmodule

// File: rtl/ioint_entry.sv
// Module: ioint_entry
// One 64-bit routing entry. It updates by halves, owns the remote-pending
// flag and flags a mask change. Assumes wr_lo and wr_hi are never both set.
module ioint_entry
    import ioint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [31:0]      wdata_i,
    input  logic             rirr_set_i,
    output logic [ENT_W-1:0] ent_o,
    output logic             mchg_o
);
    // Entry storage: clear before set on remote-pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_o  <= ENT_W'(1) << MASK_B;
            mchg_o <= 1'b0;
        end else begin
            mchg_o <= 1'b0;
            if (wr_lo_i) begin
                ent_o[31:0]    <= wdata_i;
                ent_o[RIRR_B]  <= 1'b0;
                mchg_o         <= (wdata_i[MASK_B] != ent_o[MASK_B]);
            end
            if (wr_hi_i) ent_o[63:32] <= wdata_i;
            if (rirr_set_i) ent_o[RIRR_B] <= 1'b1;
        end
    end

    // R6: low write without set leaves remote-pending clear.
    a_r6_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !rirr_set_i) |=> !ent_o[RIRR_B]);
    // R6: a set always lands, even against a low write.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rirr_set_i |=> ent_o[RIRR_B]);
    // R6: with neither source, the flag holds.
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_i && !rirr_set_i) |=> $stable(ent_o[RIRR_B]));
    // R4: a high write keeps the low word.
    a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !rirr_set_i) |=> $stable(ent_o[31:0]));
    // R8: a change flag means the mask really moved.
    a_r8_real_change: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_o |-> (ent_o[MASK_B] != $past(ent_o[MASK_B])));
endmodule

// File: rtl/ioint_rd_mux.sv
// Module: ioint_rd_mux
// Forms the read word for the current offset and select and registers it on
// a read strobe. Assumes the decoder has already range-checked the index.
module ioint_rd_mux
    import ioint_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_rd_i,
    input  logic [7:0]             bus_addr_i,
    input  logic [7:0]             sel_i,
    input  logic [ID_W-1:0]        id_i,
    input  rd_kind_e               rd_kind_i,
    input  logic [6:0]             idx_i,
    input  logic [NPINS*ENT_W-1:0] tbl_i,
    output logic [31:0]            rdata_o
);
    localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

    logic [ENT_W-1:0] ent_pick;
    logic [31:0]      win_word;
    logic [31:0]      rd_word;

    // Entry selection by index.
    always_comb begin
        ent_pick = '0;
        for (int n = 0; n < NPINS; n++) begin
            if (idx_i == 7'(n)) ent_pick = tbl_i[n*ENT_W +: ENT_W];
        end
    end

    // Window word by source kind.
    always_comb begin
        unique case (rd_kind_i)
            RK_ID:   win_word = 32'(id_i) << ID_LO;
            RK_VER:  win_word = {8'h00, MAXPIN, 8'h00, VER_CODE};
            RK_TBL:  win_word = sel_i[0] ? ent_pick[63:32] : ent_pick[31:0];
            default: win_word = '0;
        endcase
    end

    // Offset decode for reads.
    always_comb begin
        if (bus_addr_i == OFS_SEL)      rd_word = {24'h0, sel_i};
        else if (bus_addr_i == OFS_WIN) rd_word = win_word;
        else                            rd_word = '0;
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_o <= '0;
        else if (bus_rd_i) rdata_o <= rd_word;
    end

    // R11: read data holds between reads.
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/ioint_regs.sv
// Module: ioint_regs (top)
// Indirectly addressed interrupt routing register file. It ties the decoder,
// control registers, per-pin entries and read path together, and encodes
// the mask-change notification. Assumes 1 <= NPINS <= 120 and single-cycle
// bus strobes.
module ioint_regs
    import ioint_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int PINW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_i,
    input  logic                   bus_rd_i,
    input  logic [7:0]             bus_addr_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            rdata_o,
    input  logic [NPINS-1:0]       rirr_set_i,
    input  logic [NPINS-1:0]       req_i,
    output logic [NPINS-1:0]       pend_o,
    output logic [NPINS*ENT_W-1:0] tbl_o,
    output logic                   mchg_valid_o,
    output logic [PINW-1:0]        mchg_pin_o,
    output logic                   mchg_mask_o
);
    logic [7:0]       sel;
    logic [ID_W-1:0]  id;
    logic             sel_we;
    logic             id_we;
    logic [NPINS-1:0] wr_lo;
    logic [NPINS-1:0] wr_hi;
    logic [NPINS-1:0] chg;
    rd_kind_e         rd_kind;
    logic [6:0]       idx;

    initial begin
        a_npins_range: assert (NPINS >= 1 && NPINS <= 120);
    end

    ioint_bus_dec #(.NPINS(NPINS)) u_dec (
        .bus_wr_i  (bus_wr_i),
        .bus_addr_i(bus_addr_i),
        .sel_i     (sel),
        .sel_we_o  (sel_we),
        .id_we_o   (id_we),
        .wr_lo_o   (wr_lo),
        .wr_hi_o   (wr_hi),
        .rd_kind_o (rd_kind),
        .idx_o     (idx)
    );

    ioint_ctl_regs #(.NPINS(NPINS)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we_i   (sel_we),
        .id_we_i    (id_we),
        .sel_wdata_i(bus_wdata_i[7:0]),
        .id_wdata_i (bus_wdata_i[ID_LO +: ID_W]),
        .req_i      (req_i),
        .sel_o      (sel),
        .id_o       (id),
        .pend_o     (pend_o)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_ent
        ioint_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo_i   (wr_lo[n]),
            .wr_hi_i   (wr_hi[n]),
            .wdata_i   (bus_wdata_i),
            .rirr_set_i(rirr_set_i[n]),
            .ent_o     (tbl_o[n*ENT_W +: ENT_W]),
            .mchg_o    (chg[n])
        );
    end

    ioint_rd_mux #(.NPINS(NPINS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd_i  (bus_rd_i),
        .bus_addr_i(bus_addr_i),
        .sel_i     (sel),
        .id_i      (id),
        .rd_kind_i (rd_kind),
        .idx_i     (idx),
        .tbl_i     (tbl_o),
        .rdata_o   (rdata_o)
    );

    // Notification encode: at most one entry flags per cycle.
    always_comb begin
        mchg_valid_o = |chg;
        mchg_pin_o   = '0;
        mchg_mask_o  = 1'b0;
        for (int n = 0; n < NPINS; n++) begin
            if (chg[n]) begin
                mchg_pin_o  = PINW'(n);
                mchg_mask_o = tbl_o[n*ENT_W + MASK_B];
            end
        end
    end

    // R8: notification from one entry at a time.
    a_r8_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));
    // R8: a notification lasts one cycle when no write follows.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mchg_valid_o && !bus_wr_i) |=> !mchg_valid_o);
    // R10: pending follows request with one cycle of delay.
    a_r10_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o == $past(req_i)));
endmodule

// File: tb/test_ioint_regs.sv
`timescale 1ns/1ps
module test_ioint_regs;
    localparam int NP = 24;
    localparam int PW = $clog2(NP);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rdata;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP-1:0]     req = '0;
    logic [NP-1:0]     pend;
    logic [NP*64-1:0]  tbl;
    logic              mchg_valid;
    logic [PW-1:0]     mchg_pin;
    logic              mchg_mask;

    ioint_regs #(.NPINS(NP)) i_ioint_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .rdata_o(rdata),
        .rirr_set_i(rirr_set), .req_i(req), .pend_o(pend), .tbl_o(tbl),
        .mchg_valid_o(mchg_valid), .mchg_pin_o(mchg_pin), .mchg_mask_o(mchg_mask)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [63:0] m_tbl [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    bit          exp_chg;
    int          exp_pin;
    bit          exp_mask;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        int idx;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return (32'(NP - 1) << 16) | 32'h11;
        if (m_sel < 8'h10) return 32'h0;
        idx = (int'(m_sel) - 16) / 2;
        if (idx >= NP) return 32'h0;
        return m_sel[0] ? m_tbl[idx][63:32] : m_tbl[idx][31:0];
    endfunction

    function automatic logic [NP*64-1:0] exp_tbl();
        logic [NP*64-1:0] v;
        for (int n = 0; n < NP; n++) v[n*64 +: 64] = m_tbl[n];
        return v;
    endfunction

    // Bus write with optional same-cycle remote-pending set; updates model.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [NP-1:0] rs);
        int idx;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; rirr_set = rs;
        exp_chg = 1'b0;
        if (a == 8'h00) m_sel = d[7:0];
        else if (a == 8'h10) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (m_sel >= 8'h10) begin
                idx = (int'(m_sel) - 16) / 2;
                if (idx < NP) begin
                    if (m_sel[0]) m_tbl[idx][63:32] = d;
                    else begin
                        if (m_tbl[idx][16] != d[16]) begin
                            exp_chg = 1'b1; exp_pin = idx; exp_mask = d[16];
                        end
                        m_tbl[idx][31:0] = d;
                        m_tbl[idx][14] = 1'b0;
                    end
                end
            end
        end
        for (int n = 0; n < NP; n++) if (rs[n]) m_tbl[n][14] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rirr_set = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        logic [31:0] e;
        e = exp_rd(a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(rdata == e, tag, 64'(rdata), 64'(e));
    endtask

    task automatic chk_after_write(input string tag);
        chk(tbl == exp_tbl(), {tag, " R9 table"}, 64'(tbl != exp_tbl()), 64'h0);
        chk(mchg_valid == exp_chg, {tag, " R8 valid"}, 64'(mchg_valid), 64'(exp_chg));
        if (exp_chg) begin
            chk(mchg_pin == PW'(exp_pin), {tag, " R8 pin"}, 64'(mchg_pin), 64'(exp_pin));
            chk(mchg_mask == exp_mask, {tag, " R8 mask"}, 64'(mchg_mask), 64'(exp_mask));
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  s;
        int          pin;
        int          op;
        void'($urandom(32'h1D5E_0A17));
        for (int n = 0; n < NP; n++) m_tbl[n] = 64'h1 << 16;
        m_sel = '0; m_id = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state.
        chk(tbl == exp_tbl(), "R7 table reset", 64'(tbl[63:0]), 64'h1_0000);
        chk(pend == '0, "R7 pend reset", 64'(pend), 64'h0);
        chk(mchg_valid == 1'b0, "R7 no notify", 64'(mchg_valid), 64'h0);
        chk(rdata == 32'h0, "R7 rdata reset", 64'(rdata), 64'h0);
        bus_read(8'h00, "R7 select reset");
        bus_read(8'h10, "R7 id reset");

        // R2 version and ignored write.
        bus_write(8'h00, 32'h01, '0);
        bus_read(8'h10, "R2 version");
        bus_write(8'h10, 32'hFFFF_FFFF, '0);
        bus_read(8'h10, "R2 version write ignored");

        // R3 ID and arbitration alias.
        bus_write(8'h00, 32'h00, '0);
        bus_write(8'h10, 32'hFA00_0000, '0);
        bus_read(8'h10, "R3 id readback");
        bus_write(8'h00, 32'h02, '0);
        bus_read(8'h10, "R3 arb reads id");
        bus_write(8'h10, 32'h0300_0000, '0);
        bus_read(8'h10, "R3 arb write ignored");

        // R1 other offsets.
        bus_write(8'h20, 32'h0000_0055, '0);
        bus_read(8'h00, "R1 select kept on other offset write");
        bus_read(8'h20, "R1 other offset reads zero");
        bus_write(8'h00, 32'hABCD_1234, '0);
        bus_read(8'h00, "R1 select 8 bits");

        // R4 unimplemented select, halves.
        bus_write(8'h00, 32'h07, '0);
        bus_write(8'h10, 32'h1234_5678, '0);
        chk_after_write("R4 unimpl write");
        bus_read(8'h10, "R4 unimpl reads zero");
        bus_write(8'h00, 32'h10 + 2 * 5 + 1, '0);
        bus_write(8'h10, 32'hC300_0000, '0);
        chk_after_write("R4 high half");
        bus_read(8'h10, "R4 high readback");

        // R8 unmask pin 3 then repeat without change.
        bus_write(8'h00, 32'h10 + 2 * 3, '0);
        bus_write(8'h10, 32'h0000_8041, '0);
        chk_after_write("R8 unmask");
        @(negedge clk);
        chk(mchg_valid == 1'b0, "R8 pulse one cycle", 64'(mchg_valid), 64'h0);
        bus_write(8'h10, 32'h0000_8042, '0);
        chk_after_write("R8 no change no pulse");

        // R5 out-of-range index.
        bus_write(8'h00, 32'(16 + 2 * NP), '0);
        bus_write(8'h10, 32'hFFFF_FFFF, '0);
        chk_after_write("R5 drop write");
        bus_read(8'h10, "R5 read zero");

        // R6 set, bus cannot set, low write clears, concurrent set wins.
        bus_write(8'h20, 32'h0, NP'(1) << 3);
        chk(tbl[3*64 + 14] == 1'b1, "R6 set pulse", 64'(tbl[3*64+14]), 64'h1);
        bus_write(8'h00, 32'h10 + 2 * 3, '0);
        bus_write(8'h10, 32'h0001_C041, '0);
        chk_after_write("R6 low write clears and bus cannot set");
        bus_write(8'h10, 32'h0000_8041, NP'(1) << 3);
        chk_after_write("R6 concurrent set wins");
        bus_read(8'h10, "R6 concurrent readback");

        // R10 pending capture.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            req = NP'($urandom);
            d = 32'(req);
            @(negedge clk);
            chk(pend == NP'(d), "R10 pend follows req", 64'(pend), 64'(d));
        end

        // Random mix.
        for (int it = 0; it < 600; it++) begin
            op = int'($urandom % 10);
            if (op < 3) begin
                s = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 8'h48);
                bus_write(8'h00, {24'($urandom), s}, '0);
            end else if (op < 7) begin
                d = $urandom;
                pin = int'($urandom % NP);
                bus_write(8'h10, d, ($urandom % 4 == 0) ? (NP'(1) << pin) : '0);
                chk_after_write("R4 R6 R8 random write");
            end else if (op < 9) begin
                bus_read(8'h10, "R4 random window read");
            end else begin
                bus_read(($urandom % 2 == 0) ? 8'h00 : 8'($urandom), "R1 R11 random offset read");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule